// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Flag-Write Mask

This unit performs one arithmetic, logic, shift or bit-transfer operation per clock for a small eight-bit processor core. The core presents a destination operand on `a_i`, a second operand on `b_i` (either a register value or an immediate), a bit index, an operation code, and the current C, T and Z status bits. The unit returns the result, a result-write strobe, a status byte and a mask. The mask names the status bits the core must overwrite; every other status bit is left as it was. The set of flags an operation writes is therefore part of the contract, alongside the values it writes.

Compare operations set flags exactly as the matching subtract does but raise no result write. Subtract-with-carry and compare-with-carry chain the zero flag, so a multi-byte compare can be built from a low-to-high sequence of byte operations. Outputs are registered by default, so a result appears one clock after its operands. The datapath width is a parameter; the nibble used for the half-carry and for the swap is always half that width.

Top module: `flag_alu`

## Requirements
- R1: Add (op 0) and add-with-carry (op 1, which also adds c_i) return the low 8 bits of the sum. C is the carry out of bit 7, H is the carry out of bit 3, and V is two's-complement overflow. The mask covers C, Z, N, V, S and H.
- R2: Subtract (op 2), subtract-with-carry (op 3, which also subtracts c_i) and negate (op 8, zero minus a_i) return the low 8 bits of the difference. C is the borrow out of bit 7, H is the borrow out of the low nibble, and V is two's-complement overflow. The mask is the same as in R1.
- R3: For ops 3 and 20, Z is 1 only when the 8-bit result is zero and z_i is 1. A set zero flag can stay set or be cleared, but is never raised.
- R4: AND (op 4), OR (op 5) and XOR (op 6) give V = 0. Their mask covers only Z, N, V and S.
- R5: Increment (op 9) and decrement (op 10) give V = 1 only for 0x7F to 0x80 and for 0x80 to 0x7F respectively. Their mask covers only Z, N, V and S.
- R6: One's complement (op 7) returns 0xFF minus a_i with C = 1 and V = 0. Its mask covers C, Z, N, V and S.
- R7: The shift and rotate ops are:
  - op 11 shifts left, with 0 entering bit 0;
  - op 12 rotates left, with c_i entering bit 0;
  - op 13 shifts right, with 0 entering bit 7;
  - op 14 rotates right, with c_i entering bit 7;
  - op 15 shifts right arithmetically, keeping bit 7.
  For all five, C takes the bit shifted out and V = N xor C. The mask covers C, Z, N, V and S.
- R8: Swap (op 16) exchanges bits 7..4 with bits 3..0 and has an empty mask.
- R9: Bit store (op 17) copies a_i[sel_i] into T, with a mask of T only and no result write. Bit load (op 18) returns a_i with bit sel_i replaced by t_i, and has an empty mask.
- R10: Compare (op 19) and compare-with-carry (op 20) produce the flags and mask of ops 2 and 3 respectively, with res_we_o low.
- R11: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6 and I=7. Z flags a zero result (R3 aside), N is result bit 7, and S = N xor V whenever S is written. I is never written.
- R12: Outputs reflect the inputs sampled at the previous rising edge. An active-low asynchronous reset drives every output to zero. Status bits outside the mask, and res_o while res_we_o is low, carry no meaning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code (see requirements) |
| a_i | input | WIDTH | Destination operand |
| b_i | input | WIDTH | Second operand, register or immediate |
| sel_i | input | log2(WIDTH) | Bit index for bit store and bit load |
| c_i | input | 1 | Current carry flag |
| t_i | input | 1 | Current T flag |
| z_i | input | 1 | Current zero flag |
| res_o | output | WIDTH | Result |
| res_we_o | output | 1 | Result must be written back |
| flags_o | output | 8 | New status bits, in status order |
| flag_we_o | output | 8 | Status bits to overwrite |

## Verification
On every cycle, the embedded properties check the following against the operation sampled one edge earlier:
- the sign flag stays consistent with N and V;
- the zero flag is never raised in a chained subtract or compare;
- compare and bit-store never raise a result write;
- swap changes no flag;
- the logic ops leave C and H alone and clear V;
- one's complement forces carry.

Arithmetic values, namely carries, half-carries and overflow at the 0x7F/0x80 boundaries, shifted-out bits, and bit-load placement, are shown only by the bench. It compares a behavioural integer model on each clock across directed corner cases and a long random operation stream.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
      OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_COM  = 5'd7,
      OP_NEG  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_LSL  = 5'd11,
      OP_ROL  = 5'd12, OP_LSR  = 5'd13, OP_ROR  = 5'd14, OP_ASR  = 5'd15,
      OP_SWAP = 5'd16, OP_BST  = 5'd17, OP_BLD  = 5'd18, OP_CP   = 5'd19,
      OP_CPC  = 5'd20
   } alu_op_e;

   // status byte layout
   localparam int F_C   = 0;
   localparam int F_Z   = 1;
   localparam int F_N   = 2;
   localparam int F_V   = 3;
   localparam int F_S   = 4;
   localparam int F_H   = 5;
   localparam int F_T   = 6;
   localparam int F_I   = 7;
   localparam int NFLAG = 8;

   function automatic logic chains_zero(alu_op_e op);
      return (op == OP_SBC) || (op == OP_CPC);
   endfunction

   function automatic logic is_addsub(alu_op_e op);
      return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBC) ||
             (op == OP_NEG) || (op == OP_CP)  || (op == OP_CPC) ||
             (op == OP_INC) || (op == OP_DEC);
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             carry_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             carry_o,
   output logic             half_o,
   output logic             ovf_o
);
   localparam int HW = WIDTH / 2;

   logic [WIDTH-1:0] b_x;
   logic             cin_x;
   logic [WIDTH:0]   full;

   // a - b - c == a + ~b + ~c ; borrows are inverted carries
   always_comb begin
      b_x     = sub_i ? ~b_i : b_i;
      cin_x   = carry_i ^ sub_i;
      full    = {1'b0, a_i} + {1'b0, b_x} + {{WIDTH{1'b0}}, cin_x};
      sum_o   = full[WIDTH-1:0];
      carry_o = full[WIDTH] ^ sub_i;
      // carry into the upper half recovered from the sum bit
      half_o  = (full[HW] ^ a_i[HW] ^ b_x[HW]) ^ sub_i;
      ovf_o   = (a_i[WIDTH-1] == b_x[WIDTH-1]) && (full[WIDTH-1] != a_i[WIDTH-1]);
   end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
   import alu_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int BW = $clog2(WIDTH),
   localparam int HW = WIDTH / 2
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [BW-1:0]    sel_i,
   input  logic             carry_i,
   input  logic             t_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o,
   output logic             t_o
);
   always_comb begin
      res_o  = a_i;
      cout_o = 1'b0;
      t_o    = a_i[sel_i];
      case (op_i)
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         OP_COM:  res_o = ~a_i;
         OP_LSL:  begin res_o = {a_i[WIDTH-2:0], 1'b0};        cout_o = a_i[WIDTH-1]; end
         OP_ROL:  begin res_o = {a_i[WIDTH-2:0], carry_i};     cout_o = a_i[WIDTH-1]; end
         OP_LSR:  begin res_o = {1'b0, a_i[WIDTH-1:1]};        cout_o = a_i[0]; end
         OP_ROR:  begin res_o = {carry_i, a_i[WIDTH-1:1]};     cout_o = a_i[0]; end
         OP_ASR:  begin res_o = {a_i[WIDTH-1], a_i[WIDTH-1:1]}; cout_o = a_i[0]; end
         OP_SWAP: res_o = {a_i[HW-1:0], a_i[WIDTH-1:HW]};
         OP_BLD:  res_o[sel_i] = t_i;
         default: res_o = a_i;
      endcase
   end
endmodule

// File: rtl/alu_flagctl.sv
module alu_flagctl
   import alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] res_i,
   input  logic             ar_c_i,
   input  logic             ar_h_i,
   input  logic             ar_v_i,
   input  logic             sh_c_i,
   input  logic             t_i,
   input  logic             z_i,
   output logic [NFLAG-1:0] flags_o,
   output logic [NFLAG-1:0] mask_o,
   output logic             res_we_o
);
   localparam logic [NFLAG-1:0] M_ZNVS  = NFLAG'((1 << F_Z) | (1 << F_N) | (1 << F_V) | (1 << F_S));
   localparam logic [NFLAG-1:0] M_CZNVS = M_ZNVS | NFLAG'(1 << F_C);
   localparam logic [NFLAG-1:0] M_ARITH = M_CZNVS | NFLAG'(1 << F_H);
   localparam logic [NFLAG-1:0] M_T     = NFLAG'(1 << F_T);

   logic zf, nf, vf;

   always_comb begin
      flags_o  = '0;
      mask_o   = '0;
      res_we_o = 1'b1;
      zf       = (res_i == '0);
      nf       = res_i[WIDTH-1];
      vf       = 1'b0;
      case (op_i)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CP, OP_CPC: begin
            flags_o[F_C] = ar_c_i;
            flags_o[F_H] = ar_h_i;
            vf           = ar_v_i;
            mask_o       = M_ARITH;
         end
         OP_INC, OP_DEC: begin
            vf     = ar_v_i;
            mask_o = M_ZNVS;
         end
         OP_AND, OP_OR, OP_XOR: mask_o = M_ZNVS;
         OP_COM: begin
            flags_o[F_C] = 1'b1;
            mask_o       = M_CZNVS;
         end
         OP_LSL, OP_ROL, OP_LSR, OP_ROR, OP_ASR: begin
            flags_o[F_C] = sh_c_i;
            vf           = nf ^ sh_c_i;
            mask_o       = M_CZNVS;
         end
         OP_BST: begin
            flags_o[F_T] = t_i;
            mask_o       = M_T;
            res_we_o     = 1'b0;
         end
         OP_SWAP, OP_BLD: mask_o = '0;
         default: res_we_o = 1'b0;
      endcase
      if ((op_i == OP_CP) || (op_i == OP_CPC)) res_we_o = 1'b0;
      if (chains_zero(op_i)) zf = zf & z_i;
      flags_o[F_Z] = zf;
      flags_o[F_N] = nf;
      flags_o[F_V] = vf;
      flags_o[F_S] = nf ^ vf;
   end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import alu_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [4:0]               op_i,
   input  logic [WIDTH-1:0]         a_i,
   input  logic [WIDTH-1:0]         b_i,
   input  logic [$clog2(WIDTH)-1:0] sel_i,
   input  logic                     c_i,
   input  logic                     t_i,
   input  logic                     z_i,
   output logic [WIDTH-1:0]         res_o,
   output logic                     res_we_o,
   output logic [7:0]               flags_o,
   output logic [7:0]               flag_we_o
);
   localparam int HW = WIDTH / 2;
   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   if ((WIDTH < 4) || ((WIDTH & (WIDTH - 1)) != 0)) begin : g_bad_width
      $error("flag_alu: WIDTH must be a power of two of at least 4");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_i);

   // operand steering for the shared adder
   logic [WIDTH-1:0] ax, bx;
   logic             cx, sx;
   always_comb begin
      ax = a_i;
      bx = b_i;
      cx = 1'b0;
      sx = 1'b0;
      case (op)
         OP_ADC:         cx = c_i;
         OP_SUB, OP_CP:  sx = 1'b1;
         OP_SBC, OP_CPC: begin cx = c_i; sx = 1'b1; end
         OP_NEG:         begin ax = '0; bx = a_i; sx = 1'b1; end
         OP_INC:         bx = ONE;
         OP_DEC:         begin bx = ONE; sx = 1'b1; end
         default:        ;
      endcase
   end

   logic [WIDTH-1:0] ar_sum, bo_res, nx_res;
   logic             ar_c, ar_h, ar_v, bo_c, bo_t;

   alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a_i(ax), .b_i(bx), .carry_i(cx), .sub_i(sx),
      .sum_o(ar_sum), .carry_o(ar_c), .half_o(ar_h), .ovf_o(ar_v)
   );

   alu_bitops #(.WIDTH(WIDTH)) u_bitops (
      .op_i(op), .a_i(a_i), .b_i(b_i), .sel_i(sel_i), .carry_i(c_i), .t_i(t_i),
      .res_o(bo_res), .cout_o(bo_c), .t_o(bo_t)
   );

   assign nx_res = is_addsub(op) ? ar_sum : bo_res;

   logic [NFLAG-1:0] nx_flags, nx_mask;
   logic             nx_we;

   alu_flagctl #(.WIDTH(WIDTH)) u_flagctl (
      .op_i(op), .res_i(nx_res), .ar_c_i(ar_c), .ar_h_i(ar_h), .ar_v_i(ar_v),
      .sh_c_i(bo_c), .t_i(bo_t), .z_i(z_i),
      .flags_o(nx_flags), .mask_o(nx_mask), .res_we_o(nx_we)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_o     <= '0;
            res_we_o  <= 1'b0;
            flags_o   <= '0;
            flag_we_o <= '0;
         end else begin
            res_o     <= nx_res;
            res_we_o  <= nx_we;
            flags_o   <= nx_flags;
            flag_we_o <= nx_mask;
         end
      end

      logic seen_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) seen_q <= 1'b0;
         else        seen_q <= 1'b1;
      end

      p_sign_r11: assert property (@(posedge clk) disable iff (!rst_n)
         flag_we_o[F_S] |-> (flags_o[F_S] == (flags_o[F_N] ^ flags_o[F_V])));

      p_zchain_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && (($past(op_i) == 5'(OP_SBC)) || ($past(op_i) == 5'(OP_CPC))) && !$past(z_i))
         |-> !flags_o[F_Z]);

      p_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && (($past(op_i) == 5'(OP_CP)) || ($past(op_i) == 5'(OP_CPC)) ||
                     ($past(op_i) == 5'(OP_BST)))) |-> !res_we_o);

      p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && ($past(op_i) == 5'(OP_SWAP)))
         |-> ((flag_we_o == '0) && (res_o == {$past(a_i[HW-1:0]), $past(a_i[WIDTH-1:HW])})));

      p_logic_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && (($past(op_i) == 5'(OP_AND)) || ($past(op_i) == 5'(OP_OR)) ||
                     ($past(op_i) == 5'(OP_XOR))))
         |-> (!flags_o[F_V] && !flag_we_o[F_C] && !flag_we_o[F_H]));

      p_com_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && ($past(op_i) == 5'(OP_COM))) |-> (flags_o[F_C] && !flags_o[F_V]));
   end else begin : g_comb
      assign res_o     = nx_res;
      assign res_we_o  = nx_we;
      assign flags_o   = nx_flags;
      assign flag_we_o = nx_mask;
   end
endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] op_i = '0;
   logic [7:0] a_i = '0, b_i = '0;
   logic [2:0] sel_i = '0;
   logic       c_i = 1'b0, t_i = 1'b0, z_i = 1'b0;
   logic [7:0] res_o, flags_o, flag_we_o;
   logic       res_we_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   flag_alu uut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i), .sel_i(sel_i),
      .c_i(c_i), .t_i(t_i), .z_i(z_i),
      .res_o(res_o), .res_we_o(res_we_o), .flags_o(flags_o), .flag_we_o(flag_we_o)
   );

   function automatic string tag_of(int op);
      case (op)
         0, 1:            return "R1";
         2, 8:            return "R2";
         3:               return "R3";
         4, 5, 6:         return "R4";
         9, 10:           return "R5";
         7:               return "R6";
         11, 12, 13, 14, 15: return "R7";
         16:              return "R8";
         17, 18:          return "R9";
         19:              return "R10";
         default:         return "R3";
      endcase
   endfunction

   function automatic int sgn(int x);
      return (x > 127) ? x - 256 : x;
   endfunction

   // behavioural reference of R1..R11, plain integer arithmetic
   task automatic model(input int op, input int a, input int b, input int sel,
                        input int c, input int t, input int z,
                        output int res, output bit we, output bit [7:0] fl, output bit [7:0] mk);
      int cf = 0, hf = 0, vf = 0, tf = 0, x, y, ci, s, sv;
      bit sub;
      res = a; we = 1'b1; mk = 8'h00;
      case (op)
         0, 1, 2, 3, 8, 19, 20: begin
            x = a; y = b;
            ci  = (op == 1 || op == 3 || op == 20) ? c : 0;
            sub = (op != 0 && op != 1);
            if (op == 8) begin x = 0; y = a; end
            if (!sub) begin
               s = x + y + ci; cf = (s > 255);
               hf = ((x % 16) + (y % 16) + ci) > 15;
               sv = sgn(x) + sgn(y) + ci;
            end else begin
               s = x - y - ci; cf = (s < 0);
               hf = ((x % 16) - (y % 16) - ci) < 0;
               sv = sgn(x) - sgn(y) - ci;
            end
            res = (s + 512) % 256;
            vf  = (sv > 127 || sv < -128);
            mk  = 8'h3F;
         end
         4: begin res = a & b; mk = 8'h1E; end
         5: begin res = a | b; mk = 8'h1E; end
         6: begin res = a ^ b; mk = 8'h1E; end
         7: begin res = 255 - a; cf = 1; mk = 8'h1F; end
         9:  begin res = (a + 1) % 256;   vf = (a == 127); mk = 8'h1E; end
         10: begin res = (a + 255) % 256; vf = (a == 128); mk = 8'h1E; end
         11: begin res = (a * 2) % 256;           cf = a / 128; mk = 8'h1F; end
         12: begin res = (a * 2) % 256 + c;       cf = a / 128; mk = 8'h1F; end
         13: begin res = a / 2;                   cf = a % 2;   mk = 8'h1F; end
         14: begin res = a / 2 + c * 128;         cf = a % 2;   mk = 8'h1F; end
         15: begin res = a / 2 + (a / 128) * 128; cf = a % 2;   mk = 8'h1F; end
         16: res = (a % 16) * 16 + a / 16;
         17: begin tf = (a >> sel) & 1; mk = 8'h40; we = 1'b0; end
         18: res = t ? (a | (1 << sel)) : (a & (255 - (1 << sel)));
         default: ;
      endcase
      if (op >= 11 && op <= 15) vf = ((res / 128) ^ cf);
      if (op == 19 || op == 20) we = 1'b0;
      fl = '0;
      fl[0] = cf[0];
      fl[1] = (res == 0) && !((op == 3 || op == 20) && z == 0);
      fl[2] = (res / 128) != 0;
      fl[3] = vf[0];
      fl[4] = fl[2] ^ fl[3];
      fl[5] = hf[0];
      fl[6] = tf[0];
   endtask

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // drive at a falling edge, compare at the next one (one register of latency, R12)
   task automatic apply(input int op, input int a, input int b, input int sel,
                        input int c, input int t, input int z);
      int er; bit ew; bit [7:0] ef, em;
      string tg;
      op_i = op[4:0]; a_i = a[7:0]; b_i = b[7:0]; sel_i = sel[2:0];
      c_i = c[0]; t_i = t[0]; z_i = z[0];
      model(op, a, b, sel, c, t, z, er, ew, ef, em);
      tg = (op == 20) ? "R10" : tag_of(op);
      @(negedge clk);
      chk(res_we_o == ew, tg, "result write", int'(res_we_o), int'(ew));
      chk(flag_we_o == em, tg, "flag mask", int'(flag_we_o), int'(em));
      chk((flags_o & em) == (ef & em), "R11", "masked flags", int'(flags_o & em), int'(ef & em));
      if (ew) chk(res_o == er[7:0], tg, "result", int'(res_o), er);
   endtask

   initial begin : watchdog
      #4_000_000;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R12: reset clears all outputs
      chk(res_o == 8'h00, "R12", "reset result", int'(res_o), 0);
      chk(res_we_o == 1'b0, "R12", "reset result write", int'(res_we_o), 0);
      chk(flags_o == 8'h00, "R12", "reset flags", int'(flags_o), 0);
      chk(flag_we_o == 8'h00, "R12", "reset mask", int'(flag_we_o), 0);
      rst_n = 1'b1;

      apply(0, 8'h7F, 8'h01, 0, 0, 0, 0);             // R1 overflow into sign
      chk(res_o == 8'h80 && flags_o[5:0] == 6'h2C, "R1", "7F+01 flags", int'(flags_o), 8'h2C);
      apply(1, 8'hFF, 8'h00, 0, 1, 0, 0);             // R1 carry in wraps to zero
      chk(flags_o[1:0] == 2'b11, "R1", "FF+0+c Z,C", int'(flags_o[1:0]), 3);
      apply(2, 8'h00, 8'h01, 0, 0, 0, 0);             // R2 borrow
      chk(res_o == 8'hFF && flags_o[0] && flags_o[5], "R2", "00-01", int'(res_o), 8'hFF);
      apply(8, 8'h80, 0, 0, 0, 0, 0);                 // R2 negate of most negative
      chk(res_o == 8'h80 && flags_o[5:0] == 6'h0D, "R2", "neg 80 flags", int'(flags_o), 8'h0D);
      apply(3, 8'h05, 8'h05, 0, 0, 0, 0);             // R3 zero result, z_i low
      chk(flags_o[1] == 1'b0, "R3", "chained Z held low", int'(flags_o[1]), 0);
      apply(3, 8'h05, 8'h05, 0, 0, 0, 1);             // R3 zero result, z_i high
      chk(flags_o[1] == 1'b1, "R3", "chained Z kept", int'(flags_o[1]), 1);
      apply(4, 8'hF0, 8'h0F, 0, 1, 0, 0);             // R4
      chk(flags_o[3] == 1'b0 && flag_we_o[0] == 1'b0, "R4", "AND V/C", int'(flags_o), 0);
      apply(9, 8'h7F, 0, 0, 1, 0, 0);                 // R5
      chk(flags_o[3] == 1'b1, "R5", "inc 7F V", int'(flags_o[3]), 1);
      apply(10, 8'h80, 0, 0, 0, 0, 0);                // R5
      chk(res_o == 8'h7F && flags_o[3], "R5", "dec 80", int'(res_o), 8'h7F);
      apply(7, 8'h00, 0, 0, 0, 0, 0);                 // R6
      chk(res_o == 8'hFF && flags_o[4:0] == 5'h15, "R6", "com 00", int'(flags_o), 8'h15);
      apply(15, 8'h81, 0, 0, 0, 0, 0);                // R7 arithmetic shift
      chk(res_o == 8'hC0 && flags_o[4:0] == 5'h15, "R7", "asr 81", int'(res_o), 8'hC0);
      apply(14, 8'h02, 0, 0, 1, 0, 0);                // R7 rotate carry in
      chk(res_o == 8'h81 && !flags_o[0], "R7", "ror 02 c", int'(res_o), 8'h81);
      apply(12, 8'h80, 0, 0, 1, 0, 0);                // R7
      chk(res_o == 8'h01 && flags_o[0], "R7", "rol 80 c", int'(res_o), 8'h01);
      apply(16, 8'h3C, 0, 0, 1, 1, 1);                // R8
      chk(res_o == 8'hC3 && flag_we_o == 8'h00, "R8", "swap 3C", int'(res_o), 8'hC3);
      apply(17, 8'h20, 0, 5, 0, 0, 0);                // R9 bit store
      chk(flags_o[6] && flag_we_o == 8'h40 && !res_we_o, "R9", "bst", int'(flag_we_o), 8'h40);
      apply(18, 8'hFF, 0, 3, 0, 0, 0);                // R9 bit load
      chk(res_o == 8'hF7 && flag_we_o == 8'h00, "R9", "bld", int'(res_o), 8'hF7);
      apply(19, 8'h03, 8'h03, 0, 0, 0, 0);            // R10
      chk(!res_we_o && flags_o[1], "R10", "cp equal", int'(res_we_o), 0);
      apply(20, 8'h10, 8'h10, 0, 0, 0, 0);            // R10 with chained zero
      chk(!res_we_o && !flags_o[1], "R10", "cpc z_i low", int'(flags_o[1]), 0);

      for (int i = 0; i < 4000; i++)
         apply(int'($urandom_range(20, 0)), int'($urandom_range(255, 0)),
               int'($urandom_range(255, 0)), int'($urandom_range(7, 0)),
               int'($urandom_range(1, 0)), int'($urandom_range(1, 0)),
               int'($urandom_range(1, 0)));

      // R12: asynchronous reset mid-stream clears outputs again
      rst_n = 1'b0;
      #1;
      chk(res_we_o == 1'b0 && flag_we_o == 8'h00 && res_o == 8'h00, "R12", "reset again",
          int'(flag_we_o), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule